// File: doc/BRIEF.md
# Single-Wire ROM Identity Slave

This block answers on an open-drain single-wire bus in place of a token that carries a fixed 64-bit identity. It never drives the line high. It watches a synchronized copy of the bus and can only enable a pull-low. The host starts every exchange. A long low pulse is a bus reset, and the slave answers it with a presence pulse. The next eight host write slots carry a ROM command byte. The slot after that begins the host read slots, and in these the slave returns its identity one bit per slot.

All timing comes from a microsecond count. A clock divider derives it from the system clock. The divider restarts on every host falling edge, so slot timing is measured from that edge. The identity value is a parameter. Its bits 7:0 are the family code, bits 55:8 the serial number and bits 63:56 the check byte. After power-up the slave waits for an idle period and then gives one announcement pulse. From then on it speaks only after a reset.

Top module: `owid_rom_slave`

## Requirements
- R1: A bus low lasting at least RESET_MIN_US (480 µs) counts as a reset when it ends, whatever the slave was doing. The command and identity position restart, so a full command and identity exchange works after a reset that interrupted a command.
- R2: On each reset, bus_pull_low rises about GAP_US (30 µs) after the bus returns high and stays high for PRESENCE_US (150 µs). No pull-low run is ever longer than PRESENCE_US.
- R3: In a command slot the bus is sampled SAMPLE_US (15 µs) after the host falling edge. A high bus gives bit 1 and a low bus gives bit 0, so a 12 µs low reads as 1 and an 18 µs low reads as 0.
- R4: The first bit received is command bit 0 and the eighth is bit 7. After the eighth bit, cmd_valid is high for exactly one cycle and cmd_byte holds the byte. cmd_byte changes only in that cycle.
- R5: In an identity slot that carries a 0, bus_pull_low rises about 1 µs after the host falling edge and falls about HOLD_US (30 µs) after it. A slot that carries a 1 gets no pull-low.
- R6: Identity slot i, counting from 0, carries ID_VALUE bit i. Byte 0 (the family code) goes out first, least significant bit first.
- R7: id_done is high for one cycle at the end of identity slot 63. After that, read slots get no pull-low until the next reset.
- R8: While reset is held, all outputs are low. BOOT_IDLE_US after reset release, the slave pulls the bus low once for BOOT_PULL_US (100 µs).
- R9: Before the first host reset, host slots cause no pull-low and no cmd_valid.
- R10: A low pulse that has already ended 1 µs after its falling edge is ignored and counts as no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Bus level seen at the pin, not yet synchronized |
| bus_pull_low | output | 1 | Enable for the open-drain pull-low |
| cmd_valid | output | 1 | One-cycle strobe when a command byte is complete |
| cmd_byte | output | CMD_BITS | Last command byte received |
| id_done | output | 1 | One-cycle strobe after the last identity slot |

## Verification
Several command bytes go in as write slots. Among them are values with mixed bit patterns, so a reversed bit order or a stuck bit shows up as a wrong byte. Write slots whose low time sits just before and just after the sample point show whether the sample falls at about 15 µs or somewhere else. A sub-microsecond glitch placed in the middle of a command separates a slave that filters glitches from one that counts them as bits. Slots sent before any reset, or after the identity has been sent, must get silence. A reset in the middle of a command shows whether the bit position really restarts.

// File: rtl/owid_pkg.sv
package owid_pkg;

  typedef enum logic [3:0] {
    ST_BOOT_WAIT,
    ST_BOOT_PULL,
    ST_IDLE,
    ST_RST_GAP,
    ST_PRESENCE,
    ST_CMD_WAIT,
    ST_CMD_SLOT,
    ST_ID_WAIT,
    ST_ID_SLOT
  } owid_state_e;

  function automatic int owid_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/owid_bus_sync.sv
module owid_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  output logic level,
  output logic fall,
  output logic rise
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // idle bus is high, so the chain resets high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], bus_in};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign fall  = prev_q & ~level;
  assign rise  = ~prev_q & level;

endmodule

// File: rtl/owid_timebase.sv
module owid_timebase #(
  parameter int CLKS_PER_US = 24,
  parameter int CNT_W       = 10,
  parameter int SAT         = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);

  logic             tick;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  generate
    if (CLKS_PER_US > 1) begin : g_div
      localparam int DIV_W = $clog2(CLKS_PER_US);
      logic [DIV_W-1:0] div_q, div_d;

      assign tick = (div_q == DIV_W'(CLKS_PER_US - 1));

      always_comb begin
        if (clr || tick) div_d = '0;
        else             div_d = div_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                                   cnt_d = '0;
    else if (tick && (cnt_q != CNT_W'(SAT)))   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/owid_shift.sv
module owid_shift #(
  parameter int                CMD_BITS = 8,
  parameter int                ID_BITS  = 64,
  parameter logic [ID_BITS-1:0] ID_VALUE = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                cmd_we,
  input  logic                cmd_bit,
  input  logic                id_adv,
  output logic [CMD_BITS-1:0] cmd_next,
  output logic                cmd_last,
  output logic                id_bit,
  output logic                id_last
);

  localparam int CB_W  = $clog2(CMD_BITS);
  localparam int IDX_W = $clog2(ID_BITS);

  logic [CMD_BITS-1:0] sr_q, sr_d;
  logic [CB_W-1:0]     cnt_q, cnt_d;
  logic [IDX_W-1:0]    idx_q, idx_d;

  // first received bit ends up in bit 0 after CMD_BITS shifts
  assign cmd_next = {cmd_bit, sr_q[CMD_BITS-1:1]};
  assign cmd_last = (cnt_q == CB_W'(CMD_BITS - 1));
  assign id_bit   = ID_VALUE[idx_q];
  assign id_last  = (idx_q == IDX_W'(ID_BITS - 1));

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    if (restart) begin
      sr_d  = '0;
      cnt_d = '0;
      idx_d = '0;
    end else begin
      if (cmd_we) begin
        sr_d  = cmd_next;
        cnt_d = cnt_q + 1'b1;
      end
      if (id_adv) idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

endmodule

// File: rtl/owid_rom_slave.sv
module owid_rom_slave import owid_pkg::*; #(
  parameter int                CLKS_PER_US  = 24,
  parameter int                BOOT_IDLE_US = 10000,
  parameter int                BOOT_PULL_US = 100,
  parameter int                RESET_MIN_US = 480,
  parameter int                GAP_US       = 30,
  parameter int                PRESENCE_US  = 150,
  parameter int                SAMPLE_US    = 15,
  parameter int                HOLD_US      = 30,
  parameter int                GLITCH_US    = 1,
  parameter int                SYNC_STAGES  = 2,
  parameter int                CMD_BITS     = 8,
  parameter int                ID_BITS      = 64,
  parameter logic [ID_BITS-1:0] ID_VALUE     = 64'h9C3A_710F_E428_B62D
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_in,
  output logic                bus_pull_low,
  output logic                cmd_valid,
  output logic [CMD_BITS-1:0] cmd_byte,
  output logic                id_done
);

  localparam int T_MAX = owid_max(owid_max(BOOT_IDLE_US, BOOT_PULL_US),
                                  owid_max(owid_max(GAP_US, PRESENCE_US),
                                           owid_max(SAMPLE_US, HOLD_US)));
  localparam int T_W   = $clog2(T_MAX + 1);
  localparam int M_W   = $clog2(RESET_MIN_US + 1);

  localparam logic [T_W-1:0] T_BOOT   = T_W'(BOOT_IDLE_US);
  localparam logic [T_W-1:0] T_BPULL  = T_W'(BOOT_PULL_US);
  localparam logic [T_W-1:0] T_GAP    = T_W'(GAP_US);
  localparam logic [T_W-1:0] T_PRES   = T_W'(PRESENCE_US);
  localparam logic [T_W-1:0] T_SAMPLE = T_W'(SAMPLE_US);
  localparam logic [T_W-1:0] T_HOLD   = T_W'(HOLD_US);
  localparam logic [T_W-1:0] T_GLITCH = T_W'(GLITCH_US);
  localparam logic [M_W-1:0] M_RESET  = M_W'(RESET_MIN_US);

  // bus edges
  logic bus_s, fall_s, rise_s;
  logic fall_evt, rst_evt;
  logic [M_W-1:0] low_us;
  logic [T_W-1:0] us_q;
  logic           tmr_clr;

  // sequencer
  owid_state_e         st_q, st_d;
  logic                pull_d, valid_d, done_d;
  logic [CMD_BITS-1:0] cmd_d;
  logic                restart, cmd_we, id_adv;
  logic [CMD_BITS-1:0] cmd_next;
  logic                cmd_last, id_bit, id_last;

  owid_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_in (bus_in),
    .level  (bus_s),
    .fall   (fall_s),
    .rise   (rise_s)
  );

  // measures how long the bus has been low since its last falling edge
  owid_timebase #(.CLKS_PER_US(CLKS_PER_US), .CNT_W(M_W), .SAT(RESET_MIN_US)) low_meter_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fall_s),
    .count (low_us)
  );

  // phase timer, restarted on every state change
  owid_timebase #(.CLKS_PER_US(CLKS_PER_US), .CNT_W(T_W), .SAT(T_MAX)) phase_tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .count (us_q)
  );

  owid_shift #(.CMD_BITS(CMD_BITS), .ID_BITS(ID_BITS), .ID_VALUE(ID_VALUE)) shift_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .cmd_we   (cmd_we),
    .cmd_bit  (bus_s),
    .id_adv   (id_adv),
    .cmd_next (cmd_next),
    .cmd_last (cmd_last),
    .id_bit   (id_bit),
    .id_last  (id_last)
  );

  // falls caused by the slave's own pull do not open a slot
  assign fall_evt = fall_s & ~bus_pull_low;
  assign rst_evt  = rise_s & (low_us >= M_RESET);
  assign tmr_clr  = (st_d != st_q);

  always_comb begin
    st_d    = st_q;
    pull_d  = 1'b0;
    valid_d = 1'b0;
    done_d  = 1'b0;
    restart = 1'b0;
    cmd_we  = 1'b0;
    id_adv  = 1'b0;

    case (st_q)
      ST_BOOT_WAIT: begin
        if (us_q >= T_BOOT) st_d = ST_BOOT_PULL;
      end
      ST_BOOT_PULL: begin
        if (us_q >= T_BPULL) st_d = ST_IDLE;
        else                 pull_d = 1'b1;
      end
      ST_IDLE: begin
        st_d = ST_IDLE;
      end
      ST_RST_GAP: begin
        if (us_q >= T_GAP) st_d = ST_PRESENCE;
      end
      ST_PRESENCE: begin
        if (us_q >= T_PRES) st_d = ST_CMD_WAIT;
        else                pull_d = 1'b1;
      end
      ST_CMD_WAIT: begin
        if (fall_evt) st_d = ST_CMD_SLOT;
      end
      ST_CMD_SLOT: begin
        if ((us_q == T_GLITCH) && bus_s) begin
          st_d = ST_CMD_WAIT;
        end else if (us_q >= T_SAMPLE) begin
          cmd_we = 1'b1;
          if (cmd_last) begin
            valid_d = 1'b1;
            st_d    = ST_ID_WAIT;
          end else begin
            st_d    = ST_CMD_WAIT;
          end
        end
      end
      ST_ID_WAIT: begin
        if (fall_evt) st_d = ST_ID_SLOT;
      end
      ST_ID_SLOT: begin
        if ((us_q == T_GLITCH) && bus_s) begin
          st_d = ST_ID_WAIT;
        end else if (us_q >= T_HOLD) begin
          id_adv = 1'b1;
          if (id_last) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            st_d   = ST_ID_WAIT;
          end
        end else begin
          pull_d = ~id_bit & (us_q >= T_GLITCH);
        end
      end
      default: st_d = ST_IDLE;
    endcase

    // a long low outranks every phase
    if (rst_evt) begin
      st_d    = ST_RST_GAP;
      restart = 1'b1;
      pull_d  = 1'b0;
      valid_d = 1'b0;
      done_d  = 1'b0;
      cmd_we  = 1'b0;
      id_adv  = 1'b0;
    end
  end

  assign cmd_d = valid_d ? cmd_next : cmd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_BOOT_WAIT;
      bus_pull_low <= 1'b0;
      cmd_valid    <= 1'b0;
      cmd_byte     <= '0;
      id_done      <= 1'b0;
    end else begin
      st_q         <= st_d;
      bus_pull_low <= pull_d;
      cmd_valid    <= valid_d;
      cmd_byte     <= cmd_d;
      id_done      <= done_d;
    end
  end

endmodule

// File: rtl/owid_checker.sv
module owid_checker import owid_pkg::*; #(
  parameter int CLKS_PER_US = 24,
  parameter int PRESENCE_US = 150,
  parameter int CMD_BITS    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_pull_low,
  input logic                cmd_valid,
  input logic [CMD_BITS-1:0] cmd_byte,
  input logic                id_done,
  input owid_state_e         state
);

  localparam int RUN_MAX = (PRESENCE_US + 1) * CLKS_PER_US;

  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            run_q <= '0;
    else if (bus_pull_low) run_q <= run_q + 1'b1;
    else                   run_q <= '0;
  end

  p_pull_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 32'(RUN_MAX));

  p_cmd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_byte) |-> cmd_valid);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    id_done |=> !id_done);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !bus_pull_low);

  p_strobe_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && id_done));

endmodule

bind owid_rom_slave owid_checker #(
  .CLKS_PER_US (CLKS_PER_US),
  .PRESENCE_US (PRESENCE_US),
  .CMD_BITS    (CMD_BITS)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_pull_low (bus_pull_low),
  .cmd_valid    (cmd_valid),
  .cmd_byte     (cmd_byte),
  .id_done      (id_done),
  .state        (st_q)
);

// File: tb/owid_rom_slave_tb_top.sv
`timescale 1ns/1ps
module owid_rom_slave_tb_top;

  localparam int          CPU     = 4;
  localparam int          BOOT_US = 40;
  localparam logic [63:0] ID      = 64'h9C3A_710F_E428_B62D;
  // each entry: {glitch inserted before bit 3, command byte}
  localparam logic [8:0]  VECS [3] = '{9'h033, 9'h1A5, 9'h00F};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_low;
  logic       bus;
  logic       bus_pull_low, cmd_valid, id_done;
  logic [7:0] cmd_byte;

  int n_tests = 0;
  int n_fail  = 0;
  int cv_cnt = 0, done_cnt = 0, pull_cnt = 0;
  logic [7:0] last_cmd = 8'h00;

  always #2 clk = ~clk;

  assign bus = !(host_low || bus_pull_low);

  owid_rom_slave #(
    .CLKS_PER_US  (CPU),
    .BOOT_IDLE_US (BOOT_US),
    .ID_VALUE     (ID)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_in       (bus),
    .bus_pull_low (bus_pull_low),
    .cmd_valid    (cmd_valid),
    .cmd_byte     (cmd_byte),
    .id_done      (id_done)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid) begin
        cv_cnt   = cv_cnt + 1;
        last_cmd = cmd_byte;
      end
      if (id_done)      done_cnt = done_cnt + 1;
      if (bus_pull_low) pull_cnt = pull_cnt + 1;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (n * CPU) @(negedge clk);
  endtask

  task automatic measure_pull(input int timeout_us, output int start_c, output int width_c);
    start_c = -1;
    width_c = 0;
    for (int c = 0; c < timeout_us * CPU; c++) begin
      @(negedge clk);
      if (bus_pull_low) begin
        start_c = c;
        break;
      end
    end
    if (start_c >= 0)
      while (bus_pull_low && width_c < 1000 * CPU) begin
        @(negedge clk);
        width_c++;
      end
  endtask

  task automatic host_reset();
    int s, w;
    host_low = 1'b1;
    wait_us(500);
    host_low = 1'b0;
    measure_pull(60, s, w);
    check(s >= 30*CPU - 2 && s <= 31*CPU + 4, "R2 presence delay", 64'(s), 64'(30*CPU));
    check(w >= 150*CPU - 4 && w <= 150*CPU + 4, "R2 presence width", 64'(w), 64'(150*CPU));
    wait_us(10);
  endtask

  task automatic host_write(input int low_us);
    host_low = 1'b1;
    wait_us(low_us);
    host_low = 1'b0;
    wait_us(64 - low_us);
  endtask

  task automatic host_glitch();
    host_low = 1'b1;
    repeat (2) @(negedge clk);
    host_low = 1'b0;
    wait_us(5);
  endtask

  task automatic host_read(output logic b, output int ps, output int pe);
    ps = -1;
    pe = -1;
    b  = 1'b1;
    host_low = 1'b1;
    for (int c = 0; c < 62 * CPU; c++) begin
      @(negedge clk);
      if (c == 3 * CPU)  host_low = 1'b0;
      if (c == 13 * CPU) b = bus;
      if (bus_pull_low && ps < 0) ps = c;
      if (!bus_pull_low && ps >= 0 && pe < 0) pe = c;
    end
    wait_us(2);
  endtask

  task automatic send_cmd(input logic [7:0] cmd, input logic glitch);
    for (int i = 0; i < 8; i++) begin
      if (glitch && i == 3) host_glitch();
      host_write(cmd[i] ? 5 : 60);
    end
  endtask

  task automatic read_id(input string tag);
    logic [63:0] got;
    logic        b;
    int          ps, pe;
    logic        timed;
    timed = 1'b0;
    got = '0;
    for (int i = 0; i < 64; i++) begin
      host_read(b, ps, pe);
      got[i] = b;
      if (!timed && !ID[i]) begin
        timed = 1'b1;
        check(ps >= 4 && ps <= 12, "R5 zero-bit pull start", 64'(ps), 64'(CPU));
        check(pe >= 116 && pe <= 130, "R5 zero-bit pull end", 64'(pe), 64'(30*CPU));
      end
      if (timed && ID[i] && ps >= 0) begin
        check(1'b0, "R5 one-bit slot pulled", 64'(ps), 64'hFFFF_FFFF_FFFF_FFFF);
      end
    end
    check(got == ID, {"R6 identity order ", tag}, got, ID);
  endtask

  initial begin
    logic b;
    int   s, w, ps, pe, cv0, dn0, pc0;
    rst_n    = 1'b0;
    host_low = 1'b0;
    repeat (5) @(negedge clk);
    check(!bus_pull_low && !cmd_valid && !id_done, "R8 outputs in reset",
          {61'd0, bus_pull_low, cmd_valid, id_done}, 64'd0);
    rst_n = 1'b1;

    // R8 power-up announcement
    measure_pull(BOOT_US + 20, s, w);
    check(s >= BOOT_US*CPU - 2 && s <= BOOT_US*CPU + 6, "R8 boot pulse delay", 64'(s), 64'(BOOT_US*CPU));
    check(w >= 100*CPU - 4 && w <= 100*CPU + 4, "R8 boot pulse width", 64'(w), 64'(100*CPU));

    // R9 no answer before the first reset
    wait_us(5);
    pc0 = pull_cnt;
    cv0 = cv_cnt;
    host_write(60);
    host_write(5);
    host_read(b, ps, pe);
    check(b == 1'b1, "R9 read slot before reset", 64'(b), 64'd1);
    check(pull_cnt == pc0, "R9 no pull before reset", 64'(pull_cnt - pc0), 64'd0);
    check(cv_cnt == cv0, "R9 no command before reset", 64'(cv_cnt - cv0), 64'd0);

    // table-driven full exchanges (R2 R3 R4 R5 R6 R7 R10)
    foreach (VECS[k]) begin
      cv0 = cv_cnt;
      dn0 = done_cnt;
      host_reset();
      send_cmd(VECS[k][7:0], VECS[k][8]);
      check(cv_cnt == cv0 + 1, VECS[k][8] ? "R10 glitch adds no bit" : "R4 one strobe per byte",
            64'(cv_cnt - cv0), 64'd1);
      check(last_cmd == VECS[k][7:0], "R4 command byte", 64'(last_cmd), 64'(VECS[k][7:0]));
      read_id($sformatf("vector %0d", k));
      check(done_cnt == dn0 + 1, "R7 done strobe", 64'(done_cnt - dn0), 64'd1);
      pc0 = pull_cnt;
      host_read(b, ps, pe);
      check(b == 1'b1 && pull_cnt == pc0, "R7 silent after identity", {63'd0, b}, 64'd1);
    end

    // R1 reset in the middle of a command restarts the sequence
    host_reset();
    host_write(5);
    host_write(60);
    host_write(5);
    cv0 = cv_cnt;
    host_reset();
    send_cmd(8'hC6, 1'b0);
    check(cv_cnt == cv0 + 1, "R1 one command after mid reset", 64'(cv_cnt - cv0), 64'd1);
    check(last_cmd == 8'hC6, "R1 command after mid reset", 64'(last_cmd), 64'hC6);
    read_id("R1 after mid reset");

    // R3 sample point sits between 12 us and 18 us of low time
    host_reset();
    host_write(12);
    host_write(18);
    host_write(12);
    host_write(18);
    host_write(10);
    host_write(20);
    host_write(5);
    host_write(60);
    check(last_cmd == 8'h55, "R3 sample point", 64'(last_cmd), 64'h55);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule